// File: doc/BRIEF.md
# Network management vector accumulator

This block gathers the network-management vectors carried by frames received in each communication cycle of a time-triggered bus controller. Every received vector is ORed into a working accumulator. When the next cycle starts, the accumulated value is moved into a published register, and the accumulator starts again from zero. The host therefore always sees the combined vector of the cycle that has just ended, and never a value that is still being built.

The vector is up to twelve bytes long. A programmable length masks off the trailing bytes. The host reads the published vector through a 16-bit port as six words. Reading word 0 takes a snapshot of the whole vector, and later reads of words 1 to 5 come from that snapshot. A multi-word read that starts at word 0 is therefore coherent, even if a cycle boundary falls between its words.

Top module: `nm_vector_accum`

## Requirements
- R1: After reset the published vector, the accumulator, the host snapshot and `rd_data` are all zero.
- R2: During cycle x, the published vector equals the OR of all vectors received in cycle x-1. It changes only on a `cycle_start` pulse.
- R3: Host word n (n = 0..5) carries vector byte 2n in bits 7:0 and byte 2n+1 in bits 15:8. Vector byte i arrives on `vec_data[8i+7:8i]`.
- R4: Bytes whose index is at or beyond the programmed length `vec_len` read as zero in the published words.
- R5: A `vec_len` above 12 acts as 12, and a `vec_len` of 0 yields an all-zero vector.
- R6: Each `vec_valid` pulse ORs one length-masked vector into the accumulator, and keeps every bit that was already set.
- R7: A read of word 0 returns published word 0 and latches all six published words. Reads of words 1..5 return the latched words until word 0 is read again.
- R8: A read at word address 6 or 7 returns zero. Read data appears on `rd_data` on the clock edge after `rd_en`, and holds until the next read.
- R9: A vector that arrives in the same clock as `cycle_start` counts towards the new cycle, not the one being published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| cycle_start | input | 1 | One-clock strobe at each communication cycle boundary |
| vec_valid | input | 1 | Received vector valid strobe |
| vec_data | input | 96 | Received vector, byte i on bits 8i+7:8i |
| vec_len | input | 4 | Programmed vector length in bytes |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host word address |
| rd_data | output | 16 | Host read data, registered |

## Verification
The hardest case to reach is a multi-word host read that is split by a cycle boundary. The stimulus reads word 0, publishes a new vector, and then reads a higher word. That read must still return the old vector's word, and a new read of word 0 must bring in the new vector. The same-clock collision of `cycle_start` and `vec_valid` is forced on purpose as well. The bench then publishes two cycles in a row to show where the colliding vector ends up.

// File: rtl/nm_vector_accum.sv
module nm_vector_accum #(
  parameter int NBYTES = 12,
  parameter int LEN_W  = 4,
  parameter int WORD_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cycle_start,
  input  logic                  vec_valid,
  input  logic [8*NBYTES-1:0]   vec_data,
  input  logic [LEN_W-1:0]      vec_len,
  input  logic                  rd_en,
  input  logic [$clog2(NBYTES/(WORD_W/8))-1:0] rd_addr,
  output logic [WORD_W-1:0]     rd_data
);
  localparam int VW     = 8 * NBYTES;
  localparam int NWORDS = NBYTES / (WORD_W / 8);
  localparam int ADDR_W = $clog2(NWORDS);

  logic [VW-1:0] len_mask, masked_in, acc, pub, snap;
  logic [WORD_W-1:0] snap_w [NWORDS];
  logic in_range;
  logic [ADDR_W-1:0] idx;

  for (genvar i = 0; i < NBYTES; i++) begin : g_mask
    assign len_mask[8*i +: 8] = {8{int'(vec_len) > i}};
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign snap_w[w] = snap[WORD_W*w +: WORD_W];
  end

  assign masked_in = vec_data & len_mask;
  assign in_range  = int'(rd_addr) < NWORDS;
  assign idx       = in_range ? rd_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      pub <= '0;
    end else if (cycle_start) begin
      pub <= acc & len_mask;
      acc <= vec_valid ? masked_in : '0;
    end else if (vec_valid) begin
      acc <= acc | masked_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap    <= '0;
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == '0) begin
        snap    <= pub;
        rd_data <= pub[WORD_W-1:0];
      end else if (in_range) begin
        rd_data <= snap_w[idx];
      end else begin
        rd_data <= '0;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (acc == '0 && pub == '0 && snap == '0 && rd_data == '0));

  p_pub_only_at_boundary_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(pub));

  p_pub_takes_acc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> pub == ($past(acc) & $past(len_mask)));

  p_mask_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> (pub & ~$past(len_mask)) == '0);

  p_or_keeps_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !cycle_start) |=> ((acc & $past(acc)) == $past(acc)) &&
                                   ((acc & $past(masked_in)) == $past(masked_in)));

  p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_addr == '0) |=> $stable(snap));

  p_oob_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !in_range) |=> rd_data == '0);

  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_fresh_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> acc == ($past(vec_valid) ? $past(masked_in) : '0));
endmodule

// File: tb/test_nm_vector_accum.sv
module test_nm_vector_accum;
  logic clk = 0, rst_n = 0;
  logic cycle_start = 0, vec_valid = 0, rd_en = 0;
  logic [95:0] vec_data = '0;
  logic [3:0]  vec_len = 4'd12;
  logic [2:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [95:0] exp_acc = '0, exp_pub = '0, exp_snap = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  nm_vector_accum i_nm_vector_accum (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .vec_valid(vec_valid),
    .vec_data(vec_data), .vec_len(vec_len), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data));

  function automatic logic [95:0] mask_of(input logic [3:0] len);
    logic [95:0] m = '0;
    for (int i = 0; i < 12; i++) if (int'(len) > i) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [95:0] v);
    @(negedge clk); vec_valid = 1; vec_data = v;
    @(negedge clk); vec_valid = 0;
    exp_acc |= v & mask_of(vec_len);
  endtask

  task automatic boundary(input bit with_vec, input logic [95:0] v);
    @(negedge clk); cycle_start = 1; vec_valid = with_vec; vec_data = v;
    @(negedge clk); cycle_start = 0; vec_valid = 0;
    exp_pub = exp_acc & mask_of(vec_len);
    exp_acc = with_vec ? (v & mask_of(vec_len)) : '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
    if (a == 0) exp_snap = exp_pub;
  endtask

  task automatic read_all(input string req);
    logic [15:0] d;
    for (int w = 0; w < 6; w++) begin
      rd(3'(w), d);
      check(req, d, exp_pub[16*w +: 16]);
    end
  endtask

  task automatic t_reset;
    check("R1", rd_data, 16'h0);
    read_all("R1");
  endtask

  task automatic t_accumulate;
    logic [15:0] d;
    vec_len = 12;
    boundary(0, '0);
    send(96'h0102_0408_1020_4080_0000_00A5);
    send(96'h8000_0001_0300_0000_C3C3_5A00);
    rd(0, d); check("R2 before boundary", d, 16'h0000);
    boundary(0, '0);
    read_all("R6 R3");
    check("R3 word0 byte order", exp_pub[15:0], 16'h5AA5);
    boundary(0, '0);
    read_all("R2 cleared");
  endtask

  task automatic t_length;
    vec_len = 5;
    send(96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF);
    boundary(0, '0);
    read_all("R4");
    vec_len = 15;
    send(96'hA5A5_A5A5_A5A5_A5A5_A5A5_A5A5);
    boundary(0, '0);
    read_all("R5 len>12");
    vec_len = 0;
    send(96'h1234_5678_9ABC_DEF0_1357_9BDF);
    boundary(0, '0);
    read_all("R5 len0");
    vec_len = 12;
  endtask

  task automatic t_collision;
    send(96'h0000_0000_0000_0000_0000_1111);
    boundary(1, 96'h2222_0000_0000_0000_0000_0000);
    read_all("R9 old cycle");
    boundary(0, '0);
    read_all("R9 new cycle");
  endtask

  task automatic t_snapshot;
    logic [15:0] d;
    logic [95:0] first;
    send(96'h1111_2222_3333_4444_5555_6666);
    boundary(0, '0);
    rd(0, d); check("R7 word0", d, exp_pub[15:0]);
    first = exp_pub;
    send(96'h9999_AAAA_BBBB_CCCC_DDDD_EEEE);
    boundary(0, '0);
    rd(3, d); check("R7 stale snapshot", d, first[63:48]);
    rd(5, d); check("R7 stale snapshot", d, first[95:80]);
    rd(0, d); check("R7 refresh", d, exp_pub[15:0]);
    rd(3, d); check("R7 refreshed", d, exp_pub[63:48]);
  endtask

  task automatic t_oob;
    logic [15:0] d;
    rd(6, d); check("R8 addr6", d, 16'h0);
    rd(7, d); check("R8 addr7", d, 16'h0);
    rd(1, d);
    repeat (3) @(negedge clk);
    check("R8 hold", rd_data, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_accumulate;
    t_length;
    t_collision;
    t_snapshot;
    t_oob;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hang expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule